// File: doc/BRIEF.md
# PCI Bus Parking and Access Controller

This controller owns the output enables of one PCI agent's shared lines: the address/data bus with the command/byte-enable lines, and the parity line. When the arbiter grants the bus and the agent has no transaction to run, the controller parks the bus by driving these lines to valid levels. The address/data and command lines are enabled first, and parity follows one clock later. When the grant is lost, every line is released on the next clock.

The agent asks an external arbiter for the bus through a request pin. In the external-arbiter configuration, this request leaves on the pin that otherwise carries grant output 0, and the arbiter's answer comes in on the pin that otherwise carries request input 0. Once the grant answers an outstanding request on an idle bus, the controller emits a one-cycle start pulse and enables the address/data lines. From that point a separate transaction engine takes over. All bus pins are active low. Every output is a register.

Top module: `pbp_park_ctrl`

## Requirements
- R1: A synchronous active-high reset sets ad_cbe_oe=0, par_oe=0, txn_start=0 and ext_req_n=1. The same values hold in the first cycle after reset is released.
- R2: The controller parks when, at a rising edge, gnt_n=0, req_pending=0 and the bus is idle. From that edge on, ad_cbe_oe=1 and ext_req_n stays 1.
- R3: While parking, par_oe rises exactly one clock after ad_cbe_oe and then stays high as long as ad_cbe_oe stays high.
- R4: If gnt_n=1 is sampled while parking, ad_cbe_oe and par_oe are both 0 after that same edge.
- R5: The bus is idle only when frame_n=1 and irdy_n=1. With either signal at 0, a grant does not cause parking.
- R6: If req_pending=1 is sampled while the controller neither parks nor starts, ext_req_n goes to 0 after that edge. It stays 0 until the grant answers or the request is withdrawn.
- R7: If gnt_n=0 is sampled on an idle bus while ext_req_n=0, then after that edge txn_start=1, ad_cbe_oe=1, par_oe=0 and ext_req_n=1.
- R8: If req_pending=1 is sampled while parking with the grant held, txn_start pulses at the next edge. ad_cbe_oe and par_oe stay 1 without a gap.
- R9: txn_start is high for exactly one cycle. In the following cycle all enables are 0.
- R10: If req_pending falls back to 0 before the grant answers, ext_req_n returns to 1 after the next edge and no start pulse occurs.
- R11: While requesting, a grant on a busy bus (frame_n=0 or irdy_n=0) does not start a transaction, and ext_req_n stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| gnt_n | input | 1 | Grant from the external arbiter, active low |
| req_pending | input | 1 | The local agent has a transaction waiting |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| ext_req_n | output | 1 | Request to the external arbiter, active low |
| ad_cbe_oe | output | 1 | Output enable for address/data and command/byte-enable lines |
| par_oe | output | 1 | Output enable for the parity line |
| txn_start | output | 1 | One-cycle pulse: the transaction may begin |

## Verification
Each input is sampled at a rising edge, and every output is a register updated at that same edge. A response to a stimulus is therefore due one cycle after the stimulus is applied. The one exception is the parity enable when parking starts, which follows a clock after that. The bench changes inputs five nanoseconds after an edge, waits for the next rising edge, and compares all four outputs five nanoseconds later. Each vector row holds the outputs expected after the edge that consumes its inputs, so the delayed parity and the one-cycle start pulse appear as successive rows.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PARK  = 2'd1,
    ST_REQ   = 2'd2,
    ST_START = 2'd3
  } pbp_state_e;
endpackage

// File: rtl/pbp_sense.sv
module pbp_sense (
  input  logic gnt_n,
  input  logic frame_n,
  input  logic irdy_n,
  output logic gnt_on,
  output logic bus_idle
);
  // Active-low pins decoded to active-high conditions (R5: idle needs both high)
  always_comb begin
    gnt_on   = ~gnt_n;
    bus_idle = frame_n & irdy_n;
  end
endmodule

// File: rtl/pbp_fsm.sv
module pbp_fsm
  import pbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       gnt_on,
  input  logic       bus_idle,
  input  logic       req_pending,
  output pbp_state_e state_q,
  output pbp_state_e state_d
);
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (req_pending)                state_d = ST_REQ;
        else if (gnt_on && bus_idle)    state_d = ST_PARK;
      end
      ST_PARK: begin
        if (!gnt_on)                    state_d = ST_IDLE;
        else if (req_pending)           state_d = ST_START;
      end
      ST_REQ: begin
        if (!req_pending)               state_d = ST_IDLE;
        else if (gnt_on && bus_idle)    state_d = ST_START;
      end
      ST_START:                         state_d = ST_IDLE;
      default:                          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // R11: a grant on a busy bus keeps the request waiting
  assert_wait_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REQ && req_pending && !bus_idle) |=> (state_q == ST_REQ));

  // R10: a withdrawn request never reaches the start state
  assert_withdraw_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REQ && !req_pending) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/pbp_drive.sv
module pbp_drive
  import pbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pbp_state_e state_d,
  output logic       ext_req_n,
  output logic       ad_cbe_oe,
  output logic       par_oe,
  output logic       txn_start
);
  logic drive_next;
  always_comb drive_next = (state_d == ST_PARK) || (state_d == ST_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_req_n <= 1'b1;
      ad_cbe_oe <= 1'b0;
      par_oe    <= 1'b0;
      txn_start <= 1'b0;
    end else begin
      ext_req_n <= (state_d != ST_REQ);
      ad_cbe_oe <= drive_next;
      // parity trails the AD/CBE enable by one clock
      par_oe    <= drive_next && ad_cbe_oe;
      txn_start <= (state_d == ST_START);
    end
  end

  assert_par_after_ad_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(par_oe) |-> (ad_cbe_oe && $past(ad_cbe_oe)));

  assert_start_single_R9: assert property (@(posedge clk) disable iff (rst)
    txn_start |=> !txn_start);

  assert_start_drives_R7: assert property (@(posedge clk) disable iff (rst)
    txn_start |-> (ad_cbe_oe && ext_req_n));
endmodule

// File: rtl/pbp_park_ctrl.sv
module pbp_park_ctrl
  import pbp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic gnt_n,
  input  logic req_pending,
  input  logic frame_n,
  input  logic irdy_n,
  output logic ext_req_n,
  output logic ad_cbe_oe,
  output logic par_oe,
  output logic txn_start
);
  logic       gnt_on;
  logic       bus_idle;
  pbp_state_e state_q;
  pbp_state_e state_d;

  pbp_sense u_sense (
    .gnt_n    (gnt_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .gnt_on   (gnt_on),
    .bus_idle (bus_idle)
  );

  pbp_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .gnt_on      (gnt_on),
    .bus_idle    (bus_idle),
    .req_pending (req_pending),
    .state_q     (state_q),
    .state_d     (state_d)
  );

  pbp_drive u_drive (
    .clk       (clk),
    .rst       (rst),
    .state_d   (state_d),
    .ext_req_n (ext_req_n),
    .ad_cbe_oe (ad_cbe_oe),
    .par_oe    (par_oe),
    .txn_start (txn_start)
  );

  assert_release_on_loss_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PARK && gnt_n) |=> (!ad_cbe_oe && !par_oe));

  assert_park_no_request_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PARK) |-> ext_req_n);

  assert_no_gap_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PARK && !gnt_n && req_pending && par_oe) |=> (ad_cbe_oe && par_oe && txn_start));
endmodule

// File: tb/pbp_park_ctrl_test.sv
module pbp_park_ctrl_test;
  logic clk = 1'b0;
  logic rst;
  logic gnt_n, req_pending, frame_n, irdy_n;
  logic ext_req_n, ad_cbe_oe, par_oe, txn_start;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pbp_park_ctrl uut (
    .clk(clk), .rst(rst), .gnt_n(gnt_n), .req_pending(req_pending),
    .frame_n(frame_n), .irdy_n(irdy_n), .ext_req_n(ext_req_n),
    .ad_cbe_oe(ad_cbe_oe), .par_oe(par_oe), .txn_start(txn_start)
  );

  // [11:8] requirement, [7] gnt_n, [6] req_pending, [5] frame_n, [4] irdy_n,
  // [3] ad_cbe_oe, [2] par_oe, [1] ext_req_n, [0] txn_start (outputs after the edge)
  localparam int NVEC = 20;
  localparam logic [11:0] VEC [NVEC] = '{
    12'h1_B2, // R1 idle, no grant
    12'h2_3A, // R2 park begins, AD/CBE only
    12'h3_3E, // R3 parity one clock later
    12'h3_3E, // R3 stays
    12'h4_B2, // R4 grant lost: release
    12'h5_12, // R5 frame busy: no park
    12'h5_22, // R5 irdy busy: no park
    12'h6_F0, // R6 request asserted
    12'h6_F0, // R6 request held
    12'hB_50, // R11 grant on busy bus: keep waiting
    12'h7_7B, // R7 start pulse
    12'h9_32, // R9 pulse ends, lines released
    12'h2_3A, // R2 park again
    12'h3_3E, // R3
    12'h8_7F, // R8 start from park, no gap
    12'h9_B2, // R9 back to idle
    12'h6_F0, // R6 request
    12'hA_B2, // R10 withdrawn, no start
    12'h2_3A, // R2 park
    12'h4_B2  // R4 release
  };

  task automatic check4(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {ad_cbe_oe, par_oe, ext_req_n, txn_start};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {ad_cbe_oe,par_oe,ext_req_n,txn_start} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; gnt_n = 1'b1; req_pending = 1'b0; frame_n = 1'b1; irdy_n = 1'b1;
    repeat (2) @(posedge clk);
    #5;
    check4("R1 in reset", 4'b0010);
    rst = 1'b0;
    @(posedge clk); #5;
    check4("R1 after release", 4'b0010);

    for (int i = 0; i < NVEC; i++) begin
      {gnt_n, req_pending, frame_n, irdy_n} = VEC[i][7:4];
      @(posedge clk); #5;
      check4($sformatf("R%0d vector %0d", VEC[i][11:8], i), VEC[i][3:0]);
    end

    // R1: reset while parking releases everything
    gnt_n = 1'b0; req_pending = 1'b0;
    @(posedge clk); #5;
    @(posedge clk); #5;
    check4("R3 park before reset", 4'b1110);
    rst = 1'b1;
    @(posedge clk); #5;
    check4("R1 reset while parking", 4'b0010);
    // R1: reset while requesting drops the request
    rst = 1'b0; gnt_n = 1'b1; req_pending = 1'b1;
    @(posedge clk); #5;
    check4("R6 request before reset", 4'b0000);
    rst = 1'b1;
    @(posedge clk); #5;
    check4("R1 reset while requesting", 4'b0010);
    rst = 1'b0; req_pending = 1'b0;
    @(posedge clk); #5;

    // R7 then R9: grant arriving with request, pulse lasts one cycle only
    req_pending = 1'b1;
    @(posedge clk); #5;
    gnt_n = 1'b0;
    @(posedge clk); #5;
    check4("R7 start after grant", 4'b1011);
    gnt_n = 1'b1; req_pending = 1'b0;
    @(posedge clk); #5;
    check4("R9 single pulse", 4'b0010);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule